// File: doc/BRIEF.md
# NAND Data-Path Hamming ECC Accumulator

This block watches the byte-wide data path of a NAND flash interface and builds a Hamming code over one block of data bytes. The code can correct any single flipped bit in the block and can detect any two flipped bits. Only data transfers to the selected NAND bank feed the code. Command cycles, address cycles and accesses to other banks leave it untouched. The code is built the same way whether the data is read from the device or written to it.

Software picks the block length with a 3-bit select, then raises an enable bit and moves data. After the programmed number of bytes has been accepted, the code freezes and a done flag rises. Lowering the enable bit clears the code, the done flag and the byte count to zero. Raising it again arms a fresh block.

Control is a three-state machine. `ST_IDLE` means disarmed and cleared. `ST_ACCUM` means counting bytes. `ST_DONE` means frozen. The transitions are:
- `arm` (ST_IDLE to ST_ACCUM), taken when the enable bit is high.
- `finish` (ST_ACCUM to ST_DONE), taken when the last byte of the block is accepted.
- `disarm` (ST_ACCUM or ST_DONE to ST_IDLE), taken when the enable bit is low.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, `code` is 0 and `done` is 0.
- R2: The block length L is 256 << `blk_sel` for `blk_sel` values 0 to 5. Values 6 and 7 select 8192. `done` rises at the clock edge that accepts the L-th byte and not earlier.
- R3: A byte is accepted at a clock edge only when `ecc_en`, `byte_vld`, `bank_hit` and `is_data` are all 1 and the block is not done. Any other cycle leaves `code` and the byte count unchanged.
- R4: `code[5:0]` holds column parities over all accepted bytes. For i = 0, 1, 2, bit 2i+1 is the XOR of every data bit whose bit position has bit i set. Bit 2i is the XOR of every data bit whose bit position has bit i clear.
- R5: Bytes are indexed 0 to L-1 in the order they are accepted. For each index bit k below N = log2(L), `code[7+2k]` is the XOR of the row parities (XOR of all 8 bits) of the bytes whose index has bit k set. `code[6+2k]` is the same XOR over the bytes whose index has bit k clear.
- R6: While armed, every bit of `code` at position 6+2N or above is 0.
- R7: While `done` is 1 and `ecc_en` stays 1, `code` holds its value, further bytes are ignored and `done` stays 1.
- R8: A cycle with `ecc_en` low clears `code`, `done` and the byte count at that clock edge. Raising `ecc_en` again starts a new block at index 0.
- R9: The control states follow the transitions arm, finish and disarm exactly as named above. A byte presented in the first armed cycle is already accepted.
- R10: Every accepted byte updates the count and all parities in one clock, so bytes may arrive on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Arm (1) / clear (0) |
| blk_sel | input | 3 | Block-length select; hold stable while armed |
| byte_vld | input | 1 | A byte is on the data path this cycle |
| bank_hit | input | 1 | The access targets this NAND bank |
| is_data | input | 1 | The access is a data transfer (not a command or address cycle) |
| din | input | 8 | Data byte |
| code | output | 32 | Accumulated code, right-aligned |
| done | output | 1 | Block complete, code frozen |

## Verification
Every result is due one clock after its stimulus. A byte sampled at a rising edge appears in `code` right after that edge. `done` rises at the same edge that accepts the final byte. A low enable clears everything at the next edge. The bench drives its inputs just after each falling edge and updates its behavioural model at the rising edge. It then compares `code` and `done` with the model at the following falling edge, so every compare falls exactly one register stage after its stimulus.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } ecc_state_t;

    // 8-bit mask of the data-bit positions whose index has bit g set
    function automatic logic [7:0] grp_mask(input int g);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = ((b >> g) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_MAX = 13,
    parameter int ADDR_MIN = 8,
    parameter int SEL_W    = 3,
    localparam int LOG_W   = $clog2(ADDR_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ecc_en,
    input  logic                take,
    input  logic [SEL_W-1:0]    blk_sel,
    output logic                accept,
    output logic                clear,
    output logic                done,
    output logic [ADDR_MAX-1:0] byte_idx,
    output logic [LOG_W-1:0]    log2len
);

    localparam int SPAN = ADDR_MAX - ADDR_MIN;

    ecc_state_t          st, nxt;
    logic [ADDR_MAX-1:0] cnt;
    logic [ADDR_MAX-1:0] last_idx;
    logic                last;

    always_comb begin
        if (int'(blk_sel) > SPAN) begin
            log2len = LOG_W'(ADDR_MAX);
        end else begin
            log2len = LOG_W'(ADDR_MIN + int'(blk_sel));
        end
        last_idx = ADDR_MAX'((1 << log2len) - 1);
        last     = (cnt == last_idx);
    end

    // next state: arm / finish / disarm
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (ecc_en) nxt = ST_ACCUM;
            ST_ACCUM: begin
                if (!ecc_en)            nxt = ST_IDLE;
                else if (take && last)  nxt = ST_DONE;
            end
            ST_DONE:  if (!ecc_en) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // outputs
    always_comb begin
        clear    = !ecc_en;
        accept   = ecc_en && take && (st != ST_DONE);
        done     = (st == ST_DONE);
        byte_idx = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (accept) cnt <= cnt + 1'b1;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACCUM) |-> (int'(cnt) < (1 << log2len)));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ecc_en) |=> done);

    p_idle_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (cnt == '0));

    p_cnt_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && !take) |=> $stable(cnt));

endmodule

// File: rtl/nand_ecc_col.sv
module nand_ecc_col
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int COL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic [DATA_W-1:0] din,
    output logic              row_par,
    output logic [COL_W-1:0]  col
);

    logic [COL_W-1:0] col_q;

    assign row_par = ^din;
    assign col     = col_q;

    for (genvar g = 0; g < 3; g++) begin : g_grp
        logic hi_bit, lo_bit;
        always_comb begin
            hi_bit = ^(din & grp_mask(g));
            lo_bit = ^(din & ~grp_mask(g));
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                col_q[2*g]   <= 1'b0;
                col_q[2*g+1] <= 1'b0;
            end else if (clear) begin
                col_q[2*g]   <= 1'b0;
                col_q[2*g+1] <= 1'b0;
            end else if (accept) begin
                col_q[2*g]   <= col_q[2*g]   ^ lo_bit;
                col_q[2*g+1] <= col_q[2*g+1] ^ hi_bit;
            end
        end
    end

endmodule

// File: rtl/nand_ecc_line.sv
module nand_ecc_line #(
    parameter int ADDR_MAX = 13,
    localparam int LOG_W   = $clog2(ADDR_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  accept,
    input  logic                  row_par,
    input  logic [ADDR_MAX-1:0]   byte_idx,
    input  logic [LOG_W-1:0]      log2len,
    output logic [2*ADDR_MAX-1:0] line
);

    for (genvar k = 0; k < ADDR_MAX; k++) begin : g_bit
        logic ev_q, od_q, used;
        assign used = (k < int'(log2len));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ev_q <= 1'b0;
                od_q <= 1'b0;
            end else if (clear) begin
                ev_q <= 1'b0;
                od_q <= 1'b0;
            end else if (accept && row_par) begin
                if (byte_idx[k]) od_q <= ~od_q;
                else             ev_q <= ~ev_q;
            end
        end
        assign line[2*k]   = ev_q & used;
        assign line[2*k+1] = od_q & used;
    end

endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
    parameter int ADDR_MAX = 13,
    parameter int ADDR_MIN = 8,
    parameter int SEL_W    = 3,
    parameter int DATA_W   = 8,
    parameter int CODE_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic [SEL_W-1:0]  blk_sel,
    input  logic              byte_vld,
    input  logic              bank_hit,
    input  logic              is_data,
    input  logic [DATA_W-1:0] din,
    output logic [CODE_W-1:0] code,
    output logic              done
);

    localparam int LOG_W  = $clog2(ADDR_MAX + 1);
    localparam int USED_W = 6 + 2 * ADDR_MAX;

    logic                  take, accept, clear, row_par;
    logic [ADDR_MAX-1:0]   byte_idx;
    logic [LOG_W-1:0]      log2len;
    logic [5:0]            col;
    logic [2*ADDR_MAX-1:0] line;

    assign take = byte_vld && bank_hit && is_data;

    nand_ecc_ctrl #(.ADDR_MAX(ADDR_MAX), .ADDR_MIN(ADDR_MIN), .SEL_W(SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .take(take), .blk_sel(blk_sel),
        .accept(accept), .clear(clear), .done(done), .byte_idx(byte_idx),
        .log2len(log2len)
    );

    nand_ecc_col #(.DATA_W(DATA_W)) u_col (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept), .din(din),
        .row_par(row_par), .col(col)
    );

    nand_ecc_line #(.ADDR_MAX(ADDR_MAX)) u_line (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept), .row_par(row_par),
        .byte_idx(byte_idx), .log2len(log2len), .line(line)
    );

    always_comb begin
        code = '0;
        code[USED_W-1:0] = {line, col};
    end

    initial begin
        a_width_fits: assert (USED_W <= CODE_W);
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en |=> (code == '0 && !done));

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ecc_en) |=> $stable(code));

    p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && !(byte_vld && bank_hit && is_data)) |=> $stable(code));

    p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en |-> ((code >> (6 + 2 * int'(log2len))) == '0));

endmodule

// File: tb/sim_nand_ecc_acc.sv
module sim_nand_ecc_acc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0;
    logic [2:0]  blk_sel = 3'd0;
    logic        byte_vld = 1'b0, bank_hit = 1'b0, is_data = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [31:0] code;
    logic        done;

    always #2 clk = ~clk;

    nand_ecc_acc u0 (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .blk_sel(blk_sel),
        .byte_vld(byte_vld), .bank_hit(bank_hit), .is_data(is_data),
        .din(din), .code(code), .done(done)
    );

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    int seed    = 7;

    // behavioural reference model
    logic [31:0] ref_code;
    bit          ref_done;
    int          ref_cnt;

    function automatic int blen(input logic [2:0] s);
        return (s > 3'd5) ? 8192 : (256 << s);
    endfunction

    function automatic int nlog(input logic [2:0] s);
        return (s > 3'd5) ? 13 : 8 + int'(s);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_code = 0; ref_done = 0; ref_cnt = 0;
        end else if (!ecc_en) begin
            ref_code = 0; ref_done = 0; ref_cnt = 0;
        end else if (!ref_done && byte_vld && bank_hit && is_data) begin
            bit rp;
            rp = ^din;
            for (int g = 0; g < 3; g++)
                for (int b = 0; b < 8; b++)
                    if (din[b]) begin
                        if ((b >> g) & 1) ref_code[2*g+1] = ~ref_code[2*g+1];
                        else              ref_code[2*g]   = ~ref_code[2*g];
                    end
            if (rp)
                for (int k = 0; k < nlog(blk_sel); k++) begin
                    if ((ref_cnt >> k) & 1) ref_code[7+2*k] = ~ref_code[7+2*k];
                    else                    ref_code[6+2*k] = ~ref_code[6+2*k];
                end
            ref_cnt++;
            if (ref_cnt == blen(blk_sel)) ref_done = 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle compare at the falling edge
    task automatic compare;
        string tag;
        vectors++;
        if (code !== ref_code || done !== ref_done) begin
            fails++;
            if (done !== ref_done)                     tag = "R2 done";
            else if (code[5:0] !== ref_code[5:0])      tag = "R4 column";
            else if ((code >> (6 + 2*nlog(blk_sel))) != 0) tag = "R6 unused";
            else                                       tag = "R5 line";
            $display("FAIL %s actual=%h/%0d expected=%h/%0d", tag, code, done, ref_code, ref_done);
        end
    endtask

    task automatic cyc(input bit en, input bit v, input bit h, input bit d, input logic [7:0] b);
        ecc_en = en; byte_vld = v; bank_hit = h; is_data = d; din = b;
        @(negedge clk);
        compare();
    endtask

    function automatic logic [7:0] rnd();
        seed = seed * 1103515245 + 12345;
        return seed[23:16];
    endfunction

    // run one block; gaps=1 mixes in ignored cycles
    task automatic run_block(input logic [2:0] s, input bit gaps);
        int acc = 0;
        int guard = 0;
        logic [7:0] r;
        blk_sel = s;
        while (!ref_done && guard < 40000) begin
            r = rnd();
            if (gaps && r[1:0] == 2'd0) begin
                cyc(1, r[2], r[3], 1'b0, rnd());   // command/address or idle cycle
                if (r[2] && r[3]) check("R3 ignored", code, ref_code);
            end else if (gaps && r[1:0] == 2'd1) begin
                cyc(1, 1'b1, 1'b0, 1'b1, rnd());   // other bank
            end else begin
                if (acc == blen(s) - 1) check("R2 not early", {31'd0, done}, 32'd0);
                cyc(1, 1'b1, 1'b1, 1'b1, rnd());
                acc++;
            end
            guard++;
        end
        check("R2 count", acc, blen(s));
        check("R9 finish", {31'd0, done}, 32'd1);
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 code", code, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 8'h00);

        // known vector: one byte 0x01 at index 0, L=256
        blk_sel = 3'd0;
        cyc(1, 1, 1, 1, 8'h01);
        check("R4 R5 R9 single byte", code, 32'h0015_5555);
        held = code;
        cyc(1, 1, 1, 0, 8'hFF);
        check("R3 address cycle", code, held);
        cyc(1, 1, 0, 1, 8'hFF);
        check("R3 other bank", code, held);
        cyc(0, 1, 1, 1, 8'hFF);
        check("R8 clear code", code, 32'd0);
        check("R8 clear done", {31'd0, done}, 32'd0);

        // L=256 with gaps, then freeze
        run_block(3'd0, 1);
        check("R6 upper zero", code >> 22, 32'd0);
        held = code;
        for (int i = 0; i < 20; i++) cyc(1, 1, 1, 1, rnd());
        check("R7 frozen", code, held);
        check("R7 done held", {31'd0, done}, 32'd1);
        cyc(0, 0, 0, 0, 8'h00);
        check("R8 cleared", code, 32'd0);

        // restart mid-block
        blk_sel = 3'd1;
        for (int i = 0; i < 100; i++) cyc(1, 1, 1, 1, rnd());
        cyc(0, 0, 0, 0, 8'h00);
        run_block(3'd1, 0);   // R10 back-to-back
        cyc(0, 0, 0, 0, 8'h00);
        run_block(3'd2, 1);
        cyc(0, 0, 0, 0, 8'h00);
        run_block(3'd3, 0);
        cyc(0, 0, 0, 0, 8'h00);
        run_block(3'd4, 1);
        cyc(0, 0, 0, 0, 8'h00);
        run_block(3'd5, 0);   // R10 8192 bytes on every cycle
        cyc(0, 0, 0, 0, 8'h00);
        run_block(3'd7, 0);
        check("R2 sel7 length", ref_cnt, 8192);
        cyc(0, 0, 0, 0, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule